// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates fourteen interrupt request lines, numbered 0 to 13, for an 8-bit microcontroller core. Software programs four 8-bit registers through a simple write port. Two of them hold the per-source enables, the master enable and the master disable. The other two hold the per-source priority bits. The controller raises a request to the core and presents a vector address and an interrupt number for the winning source. Lower numbers win within a priority level, and any high-priority source beats every low-priority one.

When the core takes the vector, it pulses an acknowledge strobe. The controller then records the number and priority level of that handler on a two-entry nesting stack. A high-priority request may interrupt a running low-priority handler. Nothing may interrupt a running high-priority handler. A return strobe pops the most recent entry. Status outputs report the level of the handler now running and whether exactly one handler is active.

Clearing the request flags is left to the peripherals; this block only reads the request lines.

Top module: `intc_two_level`

## Requirements
- R1: While reset is high and after it is released, all enable bits, priority bits, the master enable and the master disable read as 0. As a result `irq_req` is 0, `exec_hi`/`exec_lo` are 00, `nest_one` is 0 and `act_num` is 0.
- R2: A write takes effect from the clock edge that samples `wr_en`. Address 0 sets the master enable from bit 7, the master disable from bit 6, and the enables of sources 5..0 from bits 5..0. Address 1 sets the enables of sources 13..6 from bits 7..0. Address 2 sets the priorities of sources 5..0 from bits 5..0. Address 3 sets the priorities of sources 13..6 from bits 7..0.
- R3: `irq_req` can be 1 only when the master enable is 1 and the master disable is 0.
- R4: A source is pending when its `src_req` bit is 1 and its enable bit is 1. A priority bit of 1 makes the source high priority; 0 makes it low priority.
- R5: Among the sources allowed to interrupt, any high-priority source wins over every low-priority one. Within one level, the lowest source number wins.
- R6: `irq_num` gives the selected number, and `irq_vec` equals 3 + 8 × `irq_num`. This is 0x0003 for source 0 and 0x006B for source 13.
- R7: While a low-priority handler runs, only high-priority sources can raise `irq_req`. While a high-priority handler runs, `irq_req` is 0.
- R8: An acknowledge with `irq_req` at 1 pushes the selected number and level. After the edge, `act_num` shows that number, and `exec_hi`/`exec_lo` read 10 for high or 01 for low.
- R9: A return pops the most recent entry, so that the earlier handler's number and level show again. A return with nothing active is ignored. An acknowledge while `irq_req` is 0 is ignored. When acknowledge and return occur in the same cycle, the acknowledge is taken and the return is ignored.
- R10: `exec_hi` and `exec_lo` are never both 1. `nest_one` is 1 exactly when one handler is active, and 0 when none or two are active.
- R11: Once `irq_req` has been 1 without an acknowledge, the next cycle keeps the same `irq_num` for as long as that source stays allowed to interrupt. This holds even if a source that would otherwise win appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 14 | Request lines, bit n is source n |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0..3) |
| wr_data | input | 8 | Register write data |
| vec_ack | input | 1 | Core took the presented vector |
| reti | input | 1 | Core finished the current handler |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | 16 | Vector address of the selected source |
| irq_num | output | 4 | Number of the selected source |
| act_num | output | 4 | Number of the handler now running |
| exec_hi | output | 1 | A high-priority handler is running |
| exec_lo | output | 1 | A low-priority handler is running |
| nest_one | output | 1 | Exactly one handler level is active |

## Verification
`irq_req`, `irq_vec` and `irq_num` follow `src_req` within the same cycle. Register writes affect them from the cycle after the write edge. The status outputs and `act_num` change on the edge that samples an acknowledge or a return. The bench drives every input just after a falling edge and compares all outputs one time unit later, well before the next rising edge. Its behavioural model advances state only at the rising edge. The same-cycle and next-cycle results are therefore each checked in exactly the cycle they are due.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // register select codes on the write port
  typedef enum logic [1:0] {
    RA_CORE_EN  = 2'd0,
    RA_EXT_EN   = 2'd1,
    RA_CORE_PRI = 2'd2,
    RA_EXT_PRI  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NSRC = 14,
  parameter int NLEG = 6,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [1:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  output logic            master_on,
  output logic            master_off,
  output logic [NSRC-1:0] src_en,
  output logic [NSRC-1:0] src_hi
);
  localparam int NEXT = NSRC - NLEG;

  always_ff @(posedge clk) begin
    if (rst) begin
      master_on  <= 1'b0;
      master_off <= 1'b0;
      src_en     <= '0;
      src_hi     <= '0;
    end else if (wr_en) begin
      unique case (reg_addr_e'(wr_addr))
        RA_CORE_EN: begin
          master_on          <= wr_data[DW-1];
          master_off         <= wr_data[DW-2];
          src_en[NLEG-1:0]   <= wr_data[NLEG-1:0];
        end
        RA_EXT_EN:   src_en[NSRC-1:NLEG] <= wr_data[NEXT-1:0];
        RA_CORE_PRI: src_hi[NLEG-1:0]    <= wr_data[NLEG-1:0];
        RA_EXT_PRI:  src_hi[NSRC-1:NLEG] <= wr_data[NEXT-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
  parameter int NSRC = 14,
  parameter int NW   = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_req,
  input  logic [NSRC-1:0] src_en,
  input  logic [NSRC-1:0] src_hi,
  input  logic            master_on,
  input  logic            master_off,
  input  logic            run_lo,
  input  logic            run_hi,
  input  logic            vec_ack,
  output logic            req,
  output logic [NW-1:0]   pick,
  output logic            pick_hi
);
  logic [NSRC-1:0] elig;
  logic            hi_any, lo_any, cand_v, held_v, held_ok;
  logic [NW-1:0]   hi_n, lo_n, cand_n, held_n;

  // eligibility: pending, globally allowed, and able to preempt
  for (genvar g = 0; g < NSRC; g++) begin : g_elig
    assign elig[g] = src_req[g] & src_en[g] & master_on & ~master_off &
                     (src_hi[g] ? ~run_hi : ~(run_hi | run_lo));
  end

  // lowest index wins inside each level
  always_comb begin
    hi_any = 1'b0;
    lo_any = 1'b0;
    hi_n   = '0;
    lo_n   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i] && src_hi[i]) begin
        hi_any = 1'b1;
        hi_n   = NW'(i);
      end
      if (elig[i] && !src_hi[i]) begin
        lo_any = 1'b1;
        lo_n   = NW'(i);
      end
    end
    cand_v = hi_any | lo_any;
    cand_n = hi_any ? hi_n : lo_n;
  end

  assign held_ok = held_v & elig[held_n];
  assign req     = held_ok | cand_v;
  assign pick    = held_ok ? held_n : cand_n;
  assign pick_hi = src_hi[pick];

  always_ff @(posedge clk) begin
    if (rst) begin
      held_v <= 1'b0;
      held_n <= '0;
    end else if (vec_ack) begin
      held_v <= 1'b0;
    end else begin
      held_v <= req;
      if (req) held_n <= pick;
    end
  end

  // R3
  mask_chk: assert property (@(posedge clk) disable iff (rst)
    (!master_on || master_off) |-> !req);
  // R7
  hi_run_block_chk: assert property (@(posedge clk) disable iff (rst)
    run_hi |-> !req);
  // R11
  vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(req) && !$past(vec_ack) && elig[$past(pick)]) |-> (pick == $past(pick)));
endmodule

// File: rtl/intc_nest.sv
module intc_nest #(
  parameter int NW    = 4,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop_req,
  input  logic          push_hi,
  input  logic [NW-1:0] push_num,
  output logic          exec_hi,
  output logic          exec_lo,
  output logic          nest_one,
  output logic [NW-1:0] act_num
);
  localparam int DPW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] stk_hi;
  logic [NW-1:0]    stk_num [DEPTH];
  logic [DPW-1:0]   depth;
  logic             pop, top_hi, active;
  logic [NW-1:0]    top_num;

  // acknowledge takes precedence over return in the same cycle
  assign pop = pop_req & ~push & (depth != '0);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        stk_hi[g]  <= 1'b0;
        stk_num[g] <= '0;
      end else if (push && depth == DPW'(g)) begin
        stk_hi[g]  <= push_hi;
        stk_num[g] <= push_num;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       depth <= '0;
    else if (push) depth <= depth + 1'b1;
    else if (pop)  depth <= depth - 1'b1;
  end

  always_comb begin
    top_hi  = 1'b0;
    top_num = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (depth == DPW'(i + 1)) begin
        top_hi  = stk_hi[i];
        top_num = stk_num[i];
      end
    end
  end

  assign active   = (depth != '0);
  assign exec_hi  = active & top_hi;
  assign exec_lo  = active & ~top_hi;
  assign nest_one = (depth == DPW'(1));
  assign act_num  = top_num;

  // R10
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(exec_hi && exec_lo));
  // R8
  push_room_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (int'(depth) < DEPTH));
  // R9
  unwind_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && depth == DPW'(DEPTH)) |=> exec_lo);
endmodule

// File: rtl/intc_two_level.sv
module intc_two_level #(
  parameter int NSRC       = 14,
  parameter int NLEG       = 6,
  parameter int DW         = 8,
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter int NEST       = 2,
  localparam int NW        = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  src_req,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             vec_ack,
  input  logic             reti,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic [NW-1:0]    irq_num,
  output logic [NW-1:0]    act_num,
  output logic             exec_hi,
  output logic             exec_lo,
  output logic             nest_one
);
  logic            master_on, master_off, pick_hi, push;
  logic [NSRC-1:0] src_en, src_hi;

  intc_regs #(.NSRC(NSRC), .NLEG(NLEG), .DW(DW)) u_regs (
    .clk, .rst, .wr_en, .wr_addr, .wr_data,
    .master_on, .master_off, .src_en, .src_hi
  );

  intc_arb #(.NSRC(NSRC), .NW(NW)) u_arb (
    .clk, .rst, .src_req, .src_en, .src_hi, .master_on, .master_off,
    .run_lo(exec_lo), .run_hi(exec_hi), .vec_ack,
    .req(irq_req), .pick(irq_num), .pick_hi
  );

  assign push = vec_ack & irq_req;

  intc_nest #(.NW(NW), .DEPTH(NEST)) u_nest (
    .clk, .rst, .push, .pop_req(reti), .push_hi(pick_hi), .push_num(irq_num),
    .exec_hi, .exec_lo, .nest_one, .act_num
  );

  assign irq_vec = VEC_W'(VEC_BASE) + VEC_W'(VEC_STRIDE) * VEC_W'(irq_num);
endmodule

// File: tb/intc_two_level_tb.sv
`timescale 1ns/1ps
module intc_two_level_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] src_req = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        vec_ack = 1'b0;
  logic        reti = 1'b0;
  logic        irq_req, exec_hi, exec_lo, nest_one;
  logic [15:0] irq_vec;
  logic [3:0]  irq_num, act_num;

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1";

  // behavioural reference state
  bit        m_on, m_off, h_v;
  bit [13:0] m_en, m_hi;
  int        h_n;
  int        q_hi[$];
  int        q_num[$];

  always #5 clk = ~clk;

  intc_two_level u_dut (
    .clk, .rst, .src_req, .wr_en, .wr_addr, .wr_data, .vec_ack, .reti,
    .irq_req, .irq_vec, .irq_num, .act_num, .exec_hi, .exec_lo, .nest_one
  );

  function automatic bit elig(int i);
    bit lo_run = (q_hi.size() > 0) && (q_hi[$] == 0);
    bit hi_run = (q_hi.size() > 0) && (q_hi[$] == 1);
    if (!(src_req[i] && m_en[i] && m_on && !m_off)) return 0;
    if (hi_run) return 0;
    if (lo_run) return m_hi[i];
    return 1;
  endfunction

  // R5 ordering, R7 preemption, R11 hold
  function automatic void model(output bit r, output int n);
    r = 0; n = 0;
    if (h_v && elig(h_n)) begin r = 1; n = h_n; return; end
    for (int lv = 1; lv >= 0; lv--)
      for (int i = 0; i < 14; i++)
        if (!r && elig(i) && m_hi[i] == lv[0]) begin r = 1; n = i; end
  endfunction

  task automatic chk(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    bit r; int n; int d;
    #1;
    model(r, n);
    d = q_hi.size();
    chk("irq_req", int'(irq_req), int'(r));
    chk("irq_num", int'(irq_num), n);
    chk("irq_vec", int'(irq_vec), 3 + 8 * n);              // R6
    chk("exec_hi", int'(exec_hi), (d > 0 && q_hi[$] == 1) ? 1 : 0);
    chk("exec_lo", int'(exec_lo), (d > 0 && q_hi[$] == 0) ? 1 : 0);
    chk("nest_one", int'(nest_one), (d == 1) ? 1 : 0);     // R10
    chk("act_num", int'(act_num), (d > 0) ? q_num[$] : 0);
    @(posedge clk);
    if (rst) begin
      m_on = 0; m_off = 0; m_en = '0; m_hi = '0; h_v = 0;
      q_hi.delete(); q_num.delete();
    end else begin
      if (vec_ack) h_v = 0;
      else begin h_v = r; if (r) h_n = n; end
      if (vec_ack && r) begin q_hi.push_back(int'(m_hi[n])); q_num.push_back(n); end
      else if (reti && q_hi.size() > 0) begin void'(q_hi.pop_back()); void'(q_num.pop_back()); end
      if (wr_en) begin                                     // R2 register map
        case (wr_addr)
          2'd0: begin m_on = wr_data[7]; m_off = wr_data[6]; m_en[5:0] = wr_data[5:0]; end
          2'd1: m_en[13:6] = wr_data;
          2'd2: m_hi[5:0] = wr_data[5:0];
          default: m_hi[13:6] = wr_data;
        endcase
      end
    end
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0;
  endtask

  task automatic pulse_ack();
    vec_ack = 1; tick(); vec_ack = 0;
  endtask

  task automatic pulse_ret();
    reti = 1; tick(); reti = 0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: reset state with all requests high
    tag = "R1"; src_req = '1;
    tick();
    rst = 0; src_req = '0;
    tick();
    // R3: gating by master enable and master disable
    tag = "R3";
    wr(2'd0, 8'h3F);
    src_req = 14'h0004;
    tick(); tick();
    wr(2'd0, 8'hFF);
    tick();
    // R4: enable path opens
    tag = "R4";
    wr(2'd0, 8'hBF);
    tick();
    // R11: held vector survives a new high-priority winner
    tag = "R11";
    src_req = 14'h0034;
    wr(2'd2, 8'h20);
    tick(); tick();
    // R5: held source drops, high-priority source 5 wins
    tag = "R5";
    src_req = 14'h0030;
    tick(); tick();
    // R6: highest number at high priority
    tag = "R6";
    wr(2'd1, 8'hFF);
    wr(2'd3, 8'h80);
    src_req = 14'h2000;
    tick(); tick();
    // R9: acknowledge with no request is ignored
    tag = "R9";
    src_req = '0;
    tick();
    pulse_ack();
    tick();
    // R8: low handler then high preemption
    tag = "R8";
    src_req = 14'h0002;
    tick();
    pulse_ack();
    tick();
    tag = "R7";
    src_req = 14'h0003;
    tick();
    src_req = 14'h2003;
    tick();
    tag = "R8";
    pulse_ack();
    tag = "R7";
    src_req = 14'h2023;
    tick();
    // R9: unwind in order, extra return ignored
    tag = "R9";
    src_req = '0;
    pulse_ret();
    tick();
    pulse_ret();
    pulse_ret();
    tick();
    // R9: acknowledge and return together
    src_req = 14'h0002;
    tick();
    vec_ack = 1; reti = 1; tick(); vec_ack = 0; reti = 0;
    tick();
    pulse_ret();
    tick();
    // R5/R7/R11 mixed traffic
    tag = "R5";
    for (int k = 0; k < 600; k++) begin
      int rv = $urandom;
      src_req = 14'($urandom);
      vec_ack = (rv[3:0] == 4'd1);
      reti    = (rv[7:4] == 4'd2);
      wr_en   = (rv[11:8] == 4'd3);
      wr_addr = rv[13:12];
      wr_data = rv[21:14] | ((rv[13:12] == 2'd0) ? 8'h80 : 8'h00);
      if (rv[13:12] == 2'd0) wr_data[6] = (rv[25:22] == 4'd0);
      tick();
    end
    vec_ack = 0; reti = 0; wr_en = 0;
    tick();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule